// File: doc/BRIEF.md
# Cartridge Bank Latch and Chip-Select Decoder

This block sits on the cartridge side of a 68000-style console slot. It turns the slot enable and the top address lines into one active-low chip enable for each of four devices: a base ROM, a pass-through ROM on a cartridge stacked on top, a supplemental ROM and a small nonvolatile save RAM. A single mode bit sets how the upper 2 MB of the slot is shared. Software sets or clears that bit with a byte write anywhere in the slot's I/O window. The console marks that window with its own strobe.

The bit resets to zero, which gives the plain ROM map. A build parameter picks one of two variants. In the first, a set bit splits the upper 2 MB between the pass-through ROM and the supplemental ROM. In the second, a set bit maps the save RAM into the lower half of the upper 2 MB. A system-mode pin moves the whole slot region up by 4 MB, for when the console runs with a disk unit attached. The decoder also gates the read strobe onto a shared output enable. For the save RAM it also produces a write enable on the low byte lane.

Top module: `cart_bank_decoder`

## Requirements
- R1: After reset the mode bit is 0. In the supplemental-ROM variant, an access at 0x300000 then selects the pass-through ROM.
- R2: On a clock edge where win_n is low and at least one of lwr_n or uwr_n is low, the mode bit takes the value of d0.
- R3: A win_n pulse with both write strobes high leaves the mode bit unchanged. A write strobe with win_n high also leaves it unchanged.
- R4: The latch does not decode address bits. A write strobed by win_n loads the bit whatever value addr_hi has.
- R5: Slot offsets 0x000000–0x1FFFFF select the base ROM (ce_base_n low), whatever the mode bit.
- R6: With the mode bit 0, slot offsets 0x200000–0x3FFFFF select the pass-through ROM (ce_pass_n low) in both variants.
- R7: In the supplemental-ROM variant with the mode bit 1, 0x200000–0x2FFFFF selects the pass-through ROM and 0x300000–0x3FFFFF selects the supplemental ROM (ce_supp_n low).
- R8: In the save-RAM variant with the mode bit 1, 0x200000–0x2FFFFF selects the save RAM (ce_sram_n low) and 0x300000–0x3FFFFF selects the pass-through ROM. The supplemental ROM is never selected in this variant.
- R9: With disk_mode low the slot region is 0x000000–0x3FFFFF. With disk_mode high it is 0x400000–0x7FFFFF, and addresses outside the active region select no device.
- R10: With slot_n high all four chip enables are high. At most one chip enable is low at any time.
- R11: rd_oe_n follows rd_n while a device is selected, and is high otherwise.
- R12: sram_we_n is low only when lwr_n is low, the save RAM is selected and the mode bit is 1. uwr_n alone never drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | ADDR_W-REGION_AW+2 | Top address lines (A23..A20 by default) |
| d0 | input | 1 | Data bus bit 0 |
| slot_n | input | 1 | Slot enable, active low |
| win_n | input | 1 | I/O-window strobe, active low |
| lwr_n | input | 1 | Low byte write strobe, active low |
| uwr_n | input | 1 | Upper byte write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| disk_mode | input | 1 | High moves the slot region up by 4 MB |
| ce_base_n | output | 1 | Base ROM chip enable |
| ce_pass_n | output | 1 | Pass-through ROM chip enable |
| ce_supp_n | output | 1 | Supplemental ROM chip enable |
| ce_sram_n | output | 1 | Save RAM chip enable |
| rd_oe_n | output | 1 | Output enable for the selected device |
| sram_we_n | output | 1 | Save RAM write enable, low byte lane |

## Verification
The bench builds two copies side by side, both with ADDR_W=24 and REGION_AW=22. One copy has SAVE_RAM_CFG=0 and the other has SAVE_RAM_CFG=1, so both variants of the upper-half map are exercised against the same stimulus. With the 22-bit region, the disk-mode shift to 0x400000 lands on a real address line. This means an access to the normal region with the shift active must select nothing. Writes strobed by the window are made with either byte strobe and with different address values, which shows that the latch ignores both the lane and the address.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    DEV_BASE = 2'd0,
    DEV_PASS = 2'd1,
    DEV_SUPP = 2'd2,
    DEV_SRAM = 2'd3
  } cbd_dev_e;

  localparam int unsigned NUM_DEV = 4;

  typedef struct packed {
    logic     hit;
    cbd_dev_e dev;
  } cbd_sel_t;

endpackage

// File: rtl/cbd_reset_sync.sv
module cbd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cbd_mode_latch.sv
module cbd_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic win_n,
  input  logic lwr_n,
  input  logic uwr_n,
  input  logic d0,
  output logic mode_o
);

  logic load_en;
  logic mode_d;
  logic mode_q;

  // a write in the window on either byte lane loads the bit
  assign load_en = ~win_n & (~lwr_n | ~uwr_n);

  always_comb begin
    mode_d = mode_q;
    if (load_en) begin
      mode_d = d0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (load_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_n && (!lwr_n || !uwr_n)) |=> (mode_o == $past(d0))); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(!win_n && (!lwr_n || !uwr_n)) |=> $stable(mode_o)); // R3

endmodule

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
  import cbd_pkg::*;
#(
  parameter int unsigned HI_W         = 4,
  parameter bit          SAVE_RAM_CFG = 1'b0
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic            disk_mode,
  input  logic            slot_n,
  input  logic            mode,
  output cbd_sel_t        sel_o
);

  localparam int unsigned RID_W = HI_W - 2;

  logic [RID_W-1:0] rid;
  logic [RID_W-1:0] rid_exp;
  logic             upper_half;
  logic             upper_qtr;
  logic             in_slot;
  cbd_dev_e         upper_dev;

  assign rid        = addr_hi[HI_W-1:2];
  assign upper_half = addr_hi[1];
  assign upper_qtr  = addr_hi[0];
  assign rid_exp    = disk_mode ? RID_W'(1) : '0;
  assign in_slot    = ~slot_n & (rid == rid_exp);

  generate
    if (SAVE_RAM_CFG) begin : g_save_ram
      always_comb begin
        upper_dev = (mode && !upper_qtr) ? DEV_SRAM : DEV_PASS;
      end
    end else begin : g_supp_rom
      always_comb begin
        upper_dev = (mode && upper_qtr) ? DEV_SUPP : DEV_PASS;
      end
    end
  endgenerate

  always_comb begin
    sel_o.hit = in_slot;
    sel_o.dev = upper_half ? upper_dev : DEV_BASE;
  end

endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
  import cbd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 24,
  parameter int unsigned REGION_AW    = 22,
  parameter bit          SAVE_RAM_CFG = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-REGION_AW+1:0]   addr_hi,
  input  logic                          d0,
  input  logic                          slot_n,
  input  logic                          win_n,
  input  logic                          lwr_n,
  input  logic                          uwr_n,
  input  logic                          rd_n,
  input  logic                          disk_mode,
  output logic                          ce_base_n,
  output logic                          ce_pass_n,
  output logic                          ce_supp_n,
  output logic                          ce_sram_n,
  output logic                          rd_oe_n,
  output logic                          sram_we_n
);

  localparam int unsigned HI_W = ADDR_W - REGION_AW + 2;

  logic                 rst_sync_n;
  logic                 mode;
  cbd_sel_t             sel;
  logic [NUM_DEV-1:0]   ce_n;

  cbd_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  cbd_mode_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .win_n  (win_n),
    .lwr_n  (lwr_n),
    .uwr_n  (uwr_n),
    .d0     (d0),
    .mode_o (mode)
  );

  cbd_region_decode #(
    .HI_W         (HI_W),
    .SAVE_RAM_CFG (SAVE_RAM_CFG)
  ) u_dec (
    .addr_hi   (addr_hi),
    .disk_mode (disk_mode),
    .slot_n    (slot_n),
    .mode      (mode),
    .sel_o     (sel)
  );

  generate
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_ce
      assign ce_n[i] = ~(sel.hit && (sel.dev == cbd_dev_e'(i)));
    end
  endgenerate

  assign ce_base_n = ce_n[DEV_BASE];
  assign ce_pass_n = ce_n[DEV_PASS];
  assign ce_supp_n = ce_n[DEV_SUPP];
  assign ce_sram_n = ce_n[DEV_SRAM];
  assign rd_oe_n   = rd_n | ~sel.hit;
  assign sram_we_n = lwr_n | ce_n[DEV_SRAM] | ~mode;

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(~{ce_sram_n, ce_supp_n, ce_pass_n, ce_base_n})); // R10

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slot_n |-> (ce_base_n && ce_pass_n && ce_supp_n && ce_sram_n && rd_oe_n)); // R10

  AST_SRAM_WE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_we_n |-> (!ce_sram_n && mode && !lwr_n)); // R12

  AST_RESET_MAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !mode); // R1

endmodule

// File: tb/tb_cart_bank_decoder.sv
module tb_cart_bank_decoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr_hi;
  logic       d0, slot_n, win_n, lwr_n, uwr_n, rd_n, disk_mode;
  logic       a_base, a_pass, a_supp, a_sram, a_oe, a_we;
  logic       b_base, b_pass, b_supp, b_sram, b_oe, b_we;
  int         n_chk = 0;
  int         n_bad = 0;

  localparam logic [3:0] SEL_BASE = 4'b1110;
  localparam logic [3:0] SEL_PASS = 4'b1101;
  localparam logic [3:0] SEL_SUPP = 4'b1011;
  localparam logic [3:0] SEL_SRAM = 4'b0111;
  localparam logic [3:0] SEL_NONE = 4'b1111;

  always #4 clk = ~clk;

  cart_bank_decoder #(.ADDR_W(24), .REGION_AW(22), .SAVE_RAM_CFG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .d0(d0), .slot_n(slot_n),
    .win_n(win_n), .lwr_n(lwr_n), .uwr_n(uwr_n), .rd_n(rd_n), .disk_mode(disk_mode),
    .ce_base_n(a_base), .ce_pass_n(a_pass), .ce_supp_n(a_supp), .ce_sram_n(a_sram),
    .rd_oe_n(a_oe), .sram_we_n(a_we));

  cart_bank_decoder #(.ADDR_W(24), .REGION_AW(22), .SAVE_RAM_CFG(1'b1)) dut_sr (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .d0(d0), .slot_n(slot_n),
    .win_n(win_n), .lwr_n(lwr_n), .uwr_n(uwr_n), .rd_n(rd_n), .disk_mode(disk_mode),
    .ce_base_n(b_base), .ce_pass_n(b_pass), .ce_supp_n(b_supp), .ce_sram_n(b_sram),
    .rd_oe_n(b_oe), .sram_we_n(b_we));

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [3:0] ce_a();
    return {a_sram, a_supp, a_pass, a_base};
  endfunction

  function automatic logic [3:0] ce_b();
    return {b_sram, b_supp, b_pass, b_base};
  endfunction

  task automatic idle();
    slot_n = 1'b1; win_n = 1'b1; lwr_n = 1'b1; uwr_n = 1'b1; rd_n = 1'b1;
    d0 = 1'b0; addr_hi = 4'h0;
  endtask

  // one window cycle; strobes held across one rising edge
  task automatic win_cycle(logic bit_v, logic use_lo, logic use_hi, logic [3:0] a);
    @(negedge clk);
    idle();
    addr_hi = a; win_n = 1'b0; d0 = bit_v;
    lwr_n = ~use_lo; uwr_n = ~use_hi;
    @(negedge clk);
    idle();
  endtask

  task automatic access(logic [23:0] a);
    addr_hi = a[23:20]; slot_n = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    access(24'h300000);
    chk("R1 reset map supp cfg", ce_a(), SEL_PASS);
    chk("R1 reset map ram cfg", ce_b(), SEL_PASS);
    idle(); #1;
    chk("R10 idle all off", ce_a() & ce_b(), SEL_NONE);
  endtask

  task automatic t_clear_map();
    win_cycle(1'b0, 1'b1, 1'b0, 4'hA);
    access(24'h000000); chk("R5 base low", ce_a(), SEL_BASE);
    access(24'h1FFFFE); chk("R5 base top", ce_b(), SEL_BASE);
    access(24'h200000); chk("R6 pass 2x supp cfg", ce_a(), SEL_PASS);
    access(24'h3FFFFE); chk("R6 pass 3x supp cfg", ce_a(), SEL_PASS);
    access(24'h200000); chk("R6 pass 2x ram cfg", ce_b(), SEL_PASS);
    idle();
  endtask

  task automatic t_set_map();
    win_cycle(1'b1, 1'b1, 1'b0, 4'hA);
    access(24'h100000); chk("R5 base with mode set", ce_a(), SEL_BASE);
    access(24'h2FFFFE); chk("R7 pass lower quarter", ce_a(), SEL_PASS);
    access(24'h300000); chk("R7 supp upper quarter", ce_a(), SEL_SUPP);
    access(24'h200000); chk("R8 sram lower quarter", ce_b(), SEL_SRAM);
    access(24'h300000); chk("R8 pass upper quarter", ce_b(), SEL_PASS);
    idle();
  endtask

  task automatic t_ignore();
    // mode is 1 here; attempts to clear that must not take
    @(negedge clk); idle(); win_n = 1'b0; d0 = 1'b0; rd_n = 1'b0;
    @(negedge clk); idle();
    access(24'h300000); chk("R3 window read ignored", ce_a(), SEL_SUPP);
    idle();
    @(negedge clk); slot_n = 1'b0; lwr_n = 1'b0; uwr_n = 1'b0; d0 = 1'b0;
    addr_hi = 4'h3;
    @(negedge clk); idle();
    access(24'h300000); chk("R3 write outside window ignored", ce_a(), SEL_SUPP);
    idle();
  endtask

  task automatic t_lanes();
    win_cycle(1'b0, 1'b0, 1'b1, 4'h0);
    access(24'h300000); chk("R2 upper lane clears, R4 addr 0", ce_a(), SEL_PASS);
    idle();
    win_cycle(1'b1, 1'b0, 1'b1, 4'hF);
    access(24'h300000); chk("R2 upper lane sets, R4 addr F", ce_a(), SEL_SUPP);
    idle();
  endtask

  task automatic t_disk();
    disk_mode = 1'b1;
    access(24'h000000); chk("R9 old region dead", ce_a(), SEL_NONE);
    access(24'h400000); chk("R9 shifted base", ce_a(), SEL_BASE);
    access(24'h700000); chk("R9 shifted supp", ce_a(), SEL_SUPP);
    access(24'h600000); chk("R9 shifted sram", ce_b(), SEL_SRAM);
    access(24'hA00000); chk("R9 outside any region", ce_b(), SEL_NONE);
    idle(); disk_mode = 1'b0;
    access(24'h400000); chk("R9 normal mode rejects 4x", ce_a(), SEL_NONE);
    idle();
  endtask

  task automatic t_read();
    rd_n = 1'b0;
    access(24'h000000); chk("R11 oe follows rd", {3'b000, a_oe}, 4'b0000);
    slot_n = 1'b1; #2;  chk("R11 oe off no slot", {3'b000, a_oe}, 4'b0001);
    access(24'h500000); chk("R11 oe off outside", {3'b000, a_oe}, 4'b0001);
    rd_n = 1'b1;
    access(24'h000000); chk("R11 oe off no read", {3'b000, a_oe}, 4'b0001);
    idle();
  endtask

  task automatic t_sram_we();
    // mode is 1
    lwr_n = 1'b0;
    access(24'h200000); chk("R12 low lane writes ram", {3'b000, b_we}, 4'b0000);
    chk("R12 supp cfg no ram write", {3'b000, a_we}, 4'b0001);
    lwr_n = 1'b1; uwr_n = 1'b0; #2;
    chk("R12 upper lane alone", {3'b000, b_we}, 4'b0001);
    uwr_n = 1'b1; lwr_n = 1'b0;
    access(24'h300000); chk("R12 no write outside ram", {3'b000, b_we}, 4'b0001);
    idle();
    win_cycle(1'b0, 1'b1, 1'b0, 4'hA);
    lwr_n = 1'b0;
    access(24'h200000); chk("R12 mode clear blocks write", {3'b000, b_we}, 4'b0001);
    chk("R8 mode clear hides ram", ce_b(), SEL_PASS);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    disk_mode = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clear_map();
    t_set_map();
    t_ignore();
    t_lanes();
    t_disk();
    t_read();
    t_sram_we();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule